// File: doc/BRIEF.md
# Three-Valued CNF Evaluator

This block judges a fixed product-of-sums Boolean formula against a partial assignment of its variables. Each variable can be false, true or not yet assigned. A search engine that assigns variables one at a time can read from the block whether the formula is already violated, already met, or still open. With that answer it decides whether to back up or go deeper. The clause structure is fixed when the block is elaborated, through two literal masks, one for positive and one for negated literals. Each mask holds one bit per variable for every clause.

The clause logic feeds a second, two-valued output. For each variable it flags whether that variable is irrelevant to covering. A variable is flagged when every clause that holds it as a positive literal is already true through some other variable. The search can then drive the variable to 0 without losing any cover. The block is purely combinational and holds no state.

Top module: `cnf3_eval`

## Requirements
- R1: Each variable takes two bits of `assign_i`, variable v at bits [2v+1:2v]. The codes are 2'b00 = false, 2'b01 = true, 2'b10 = unassigned, and 2'b11 is read exactly like 2'b10.
- R2: A clause is true when at least one of its literals is true. A negated literal is true when its variable is false.
- R3: A clause is false when every literal in it is false.
- R4: A clause that is neither true nor false is unassigned, and the negation of an unassigned variable is unassigned.
- R5: `formula_o` is 2'b00 whenever any clause is false, even when other clauses are unassigned.
- R6: `formula_o` is 2'b01 exactly when every clause is true.
- R7: In every other case `formula_o` is 2'b10, and `formula_o` never shows 2'b11.
- R8: `dont_care_o[i]` is 1 exactly when each clause holding variable i as a positive literal contains a true literal of some variable other than i. Unassigned literals never count as true.
- R9: The value of variable i itself has no effect on `dont_care_o[i]`.
- R10: A variable that appears in no clause as a positive literal is always flagged in `dont_care_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| assign_i | input | 2*NUM_VARS | Packed three-valued assignment, variable v at bits [2v+1:2v] |
| formula_o | output | 2 | Three-valued formula verdict: 00 false, 01 true, 10 open |
| dont_care_o | output | NUM_VARS | Per-variable flag: covering does not need this variable |

## Verification
Directed vectors set the all-unassigned and all-2'b11 patterns apart, which tests that the spare code aliases to unassigned. They also cover a full satisfying assignment and a single false clause among open ones, which tests that false wins over open. Random partial assignments mix all four codes, and each one is compared against a model of clause, formula and flag outputs. For the flag output, the bench holds every other variable fixed and steps one variable through all four codes. A flag that moves shows that the variable's own value leaks into its own don't-care decision. A variable that has no positive literal shows whether the empty-condition case is flagged.

// File: rtl/cnf3_pkg.sv
// Package: shared three-valued type and helpers for the CNF evaluator.
// Assumes the encoding 00 false, 01 true, 1x unassigned.
package cnf3_pkg;
    typedef logic [1:0] tv_t;

    localparam tv_t TV_F = 2'b00;
    localparam tv_t TV_T = 2'b01;
    localparam tv_t TV_U = 2'b10;

    // Fold the spare code 2'b11 onto the canonical unassigned code.
    function automatic tv_t tv_norm(input tv_t a);
        return a[1] ? TV_U : a;
    endfunction

    // Three-valued negation: false and true swap, unassigned stays.
    function automatic tv_t tv_not(input tv_t a);
        tv_t n;
        n = tv_norm(a);
        case (n)
            TV_F:    return TV_T;
            TV_T:    return TV_F;
            default: return TV_U;
        endcase
    endfunction
endpackage

// File: rtl/cnf3_literal_stage.sv
// Module: per-variable literal status for one clause.
// For every variable it reports whether the clause holds a true literal of it,
// and whether the clause holds an unassigned literal of it.
// Assumes the masks are constant; absent literals contribute nothing.
module cnf3_literal_stage
    import cnf3_pkg::*;
#(
    parameter int NUM_VARS = 6,
    parameter logic [NUM_VARS-1:0] POS = '0,
    parameter logic [NUM_VARS-1:0] NEG = '0
) (
    input  logic [2*NUM_VARS-1:0] assign_i,
    output logic [NUM_VARS-1:0]   lit_true_o,
    output logic [NUM_VARS-1:0]   lit_open_o
);
    for (genvar v = 0; v < NUM_VARS; v++) begin : g_var
        tv_t val;
        tv_t pos_lit;
        tv_t neg_lit;

        // Normalise the variable and form its two literal values.
        always_comb begin
            val     = tv_norm(assign_i[2*v +: 2]);
            pos_lit = val;
            neg_lit = tv_not(val);
        end

        // Combine the literals present in this clause.
        always_comb begin
            lit_true_o[v] = (POS[v] && pos_lit == TV_T) || (NEG[v] && neg_lit == TV_T);
            lit_open_o[v] = (POS[v] && pos_lit == TV_U) || (NEG[v] && neg_lit == TV_U);
        end
    end
endmodule

// File: rtl/cnf3_clause_eval.sv
// Module: three-valued OR of one clause, plus the per-variable
// "true without this variable" signals that the don't-care logic shares.
// Assumes the masks are constant; an empty clause evaluates to false.
module cnf3_clause_eval
    import cnf3_pkg::*;
#(
    parameter int NUM_VARS = 6,
    parameter logic [NUM_VARS-1:0] POS = '0,
    parameter logic [NUM_VARS-1:0] NEG = '0
) (
    input  logic [2*NUM_VARS-1:0] assign_i,
    output tv_t                   clause_o,
    output logic [NUM_VARS-1:0]   excl_true_o
);
    logic [NUM_VARS-1:0] lit_true;
    logic [NUM_VARS-1:0] lit_open;

    cnf3_literal_stage #(
        .NUM_VARS (NUM_VARS),
        .POS      (POS),
        .NEG      (NEG)
    ) u_lits (
        .assign_i   (assign_i),
        .lit_true_o (lit_true),
        .lit_open_o (lit_open)
    );

    // Clause verdict: any true literal wins, then any open literal.
    always_comb begin
        if (|lit_true)      clause_o = TV_T;
        else if (|lit_open) clause_o = TV_U;
        else                clause_o = TV_F;
    end

    for (genvar i = 0; i < NUM_VARS; i++) begin : g_excl
        localparam logic [NUM_VARS-1:0] KEEP = ~(NUM_VARS'(1) << i);
        // True literal present among the other variables only.
        always_comb excl_true_o[i] = |(lit_true & KEEP);
    end
endmodule

// File: rtl/cnf3_formula_join.sv
// Module: three-valued AND of all clause verdicts.
// Assumes clause inputs are canonical (never 2'b11); output is canonical too.
module cnf3_formula_join
    import cnf3_pkg::*;
#(
    parameter int NUM_CLAUSES = 5
) (
    input  tv_t [NUM_CLAUSES-1:0] clause_i,
    output tv_t                   formula_o
);
    logic any_false;
    logic all_true;

    // Scan the clauses for a false one and for a non-true one.
    always_comb begin
        any_false = 1'b0;
        all_true  = 1'b1;
        for (int c = 0; c < NUM_CLAUSES; c++) begin
            if (clause_i[c] == TV_F) any_false = 1'b1;
            if (clause_i[c] != TV_T) all_true  = 1'b0;
        end
    end

    // False dominates, then a fully true set, else open.
    always_comb begin
        if (any_false)     formula_o = TV_F;
        else if (all_true) formula_o = TV_T;
        else               formula_o = TV_U;
    end
endmodule

// File: rtl/cnf3_dontcare.sv
// Module: two-valued don't-care flag per variable.
// A variable is flagged when every clause holding it positively is true
// through another variable. Assumes the positive mask is constant.
module cnf3_dontcare #(
    parameter int NUM_VARS    = 6,
    parameter int NUM_CLAUSES = 5,
    parameter logic [NUM_CLAUSES*NUM_VARS-1:0] POS_MASK = '0
) (
    input  logic [NUM_CLAUSES-1:0][NUM_VARS-1:0] excl_true_i,
    output logic [NUM_VARS-1:0]                  dont_care_o
);
    for (genvar i = 0; i < NUM_VARS; i++) begin : g_var
        // Every clause that needs variable i positively must already be covered.
        always_comb begin
            dont_care_o[i] = 1'b1;
            for (int c = 0; c < NUM_CLAUSES; c++) begin
                if (POS_MASK[c*NUM_VARS + i] && !excl_true_i[c][i])
                    dont_care_o[i] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/cnf3_eval.sv
// Module: top of the three-valued CNF evaluator.
// One clause evaluator per clause feeds the formula join and the don't-care
// logic. Purely combinational. Clause c uses mask bits [c*NUM_VARS +: NUM_VARS].
module cnf3_eval
    import cnf3_pkg::*;
#(
    parameter int NUM_VARS    = 6,
    parameter int NUM_CLAUSES = 5,
    parameter logic [NUM_CLAUSES*NUM_VARS-1:0] POS_MASK =
        30'b000010_011000_001000_000100_000011,
    parameter logic [NUM_CLAUSES*NUM_VARS-1:0] NEG_MASK =
        30'b010000_100000_000100_000011_000000
) (
    input  logic [2*NUM_VARS-1:0] assign_i,
    output logic [1:0]            formula_o,
    output logic [NUM_VARS-1:0]   dont_care_o
);
    tv_t  [NUM_CLAUSES-1:0]               clause_val;
    logic [NUM_CLAUSES-1:0][NUM_VARS-1:0] excl_true;

    for (genvar c = 0; c < NUM_CLAUSES; c++) begin : g_clause
        cnf3_clause_eval #(
            .NUM_VARS (NUM_VARS),
            .POS      (POS_MASK[c*NUM_VARS +: NUM_VARS]),
            .NEG      (NEG_MASK[c*NUM_VARS +: NUM_VARS])
        ) u_clause (
            .assign_i    (assign_i),
            .clause_o    (clause_val[c]),
            .excl_true_o (excl_true[c])
        );
    end

    cnf3_formula_join #(
        .NUM_CLAUSES (NUM_CLAUSES)
    ) u_join (
        .clause_i  (clause_val),
        .formula_o (formula_o)
    );

    cnf3_dontcare #(
        .NUM_VARS    (NUM_VARS),
        .NUM_CLAUSES (NUM_CLAUSES),
        .POS_MASK    (POS_MASK)
    ) u_dc (
        .excl_true_i (excl_true),
        .dont_care_o (dont_care_o)
    );
endmodule

// File: rtl/cnf3_eval_chk.sv
// Checker: immediate assertions relating clause verdicts, the formula
// verdict and the don't-care flags. Bound into cnf3_eval below.
module cnf3_eval_chk #(
    parameter int NUM_VARS    = 6,
    parameter int NUM_CLAUSES = 5,
    parameter logic [NUM_CLAUSES*NUM_VARS-1:0] POS_MASK = '0
) (
    input logic [NUM_CLAUSES-1:0][1:0] clause_val,
    input logic [1:0]                  formula_o,
    input logic [NUM_VARS-1:0]         dont_care_o
);
    // Clause verdicts stay in the canonical encoding.
    always_comb begin
        for (int c = 0; c < NUM_CLAUSES; c++) begin
            assert_clause_canon_R4: assert (clause_val[c] != 2'b11)
                else $error("clause %0d shows 2'b11", c);
        end
    end

    // Formula never shows the spare code.
    always_comb begin
        assert_formula_canon_R7: assert (formula_o != 2'b11)
            else $error("formula shows 2'b11");
    end

    // Any false clause forces a false formula; all true clauses force true.
    always_comb begin
        logic any_f;
        logic all_t;
        any_f = 1'b0;
        all_t = 1'b1;
        for (int c = 0; c < NUM_CLAUSES; c++) begin
            if (clause_val[c] == 2'b00) any_f = 1'b1;
            if (clause_val[c] != 2'b01) all_t = 1'b0;
        end
        assert_false_dominates_R5: assert (!any_f || formula_o == 2'b00)
            else $error("false clause but formula %b", formula_o);
        assert_all_true_R6: assert (!all_t || formula_o == 2'b01)
            else $error("all clauses true but formula %b", formula_o);
    end

    // A flagged variable has every positive-holding clause already true.
    always_comb begin
        for (int i = 0; i < NUM_VARS; i++) begin
            for (int c = 0; c < NUM_CLAUSES; c++) begin
                assert_dc_covered_R8: assert (!(dont_care_o[i] && POS_MASK[c*NUM_VARS+i])
                                              || clause_val[c] == 2'b01)
                    else $error("var %0d flagged but clause %0d not true", i, c);
            end
        end
    end

    // A variable without any positive literal is always flagged.
    always_comb begin
        for (int i = 0; i < NUM_VARS; i++) begin
            logic has_pos;
            has_pos = 1'b0;
            for (int c = 0; c < NUM_CLAUSES; c++)
                if (POS_MASK[c*NUM_VARS+i]) has_pos = 1'b1;
            assert_dc_unused_R10: assert (has_pos || dont_care_o[i])
                else $error("var %0d has no positive literal but is not flagged", i);
        end
    end
endmodule

bind cnf3_eval cnf3_eval_chk #(
    .NUM_VARS    (NUM_VARS),
    .NUM_CLAUSES (NUM_CLAUSES),
    .POS_MASK    (POS_MASK)
) u_chk (
    .clause_val  (clause_val),
    .formula_o   (formula_o),
    .dont_care_o (dont_care_o)
);

// File: tb/tb_cnf3_eval.sv
module tb_cnf3_eval;
    localparam int NV = 6;
    localparam int NC = 5;
    localparam logic [NC*NV-1:0] PM = 30'b000010_011000_001000_000100_000011;
    localparam logic [NC*NV-1:0] NM = 30'b010000_100000_000100_000011_000000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [2*NV-1:0] assign_i;
    logic [1:0]      formula_o;
    logic [NV-1:0]   dont_care_o;
    int              total = 0;
    int              bad = 0;
    logic            done = 1'b0;

    always #2.5 clk = ~clk;

    cnf3_eval #(.NUM_VARS(NV), .NUM_CLAUSES(NC), .POS_MASK(PM), .NEG_MASK(NM)) dut (
        .assign_i    (assign_i),
        .formula_o   (formula_o),
        .dont_care_o (dont_care_o)
    );

    // Model: variable value with 11 read as unassigned (R1)
    function automatic logic [1:0] m_var(input logic [2*NV-1:0] a, input int v);
        logic [1:0] x;
        x = a[2*v +: 2];
        return (x == 2'b11) ? 2'b10 : x;
    endfunction

    // Model: is any literal of v in clause c true; is any unassigned
    function automatic logic m_lit_true(input logic [2*NV-1:0] a, input int c, input int v);
        logic [1:0] x;
        x = m_var(a, v);
        return (PM[c*NV+v] && x == 2'b01) || (NM[c*NV+v] && x == 2'b00);
    endfunction

    function automatic logic m_lit_open(input logic [2*NV-1:0] a, input int c, input int v);
        return (PM[c*NV+v] || NM[c*NV+v]) && m_var(a, v) == 2'b10;
    endfunction

    function automatic logic [1:0] m_clause(input logic [2*NV-1:0] a, input int c);
        logic t, o;
        t = 0; o = 0;
        for (int v = 0; v < NV; v++) begin
            if (m_lit_true(a, c, v)) t = 1;
            if (m_lit_open(a, c, v)) o = 1;
        end
        return t ? 2'b01 : (o ? 2'b10 : 2'b00);
    endfunction

    function automatic logic [1:0] m_formula(input logic [2*NV-1:0] a);
        logic f, allt;
        f = 0; allt = 1;
        for (int c = 0; c < NC; c++) begin
            if (m_clause(a, c) == 2'b00) f = 1;
            if (m_clause(a, c) != 2'b01) allt = 0;
        end
        return f ? 2'b00 : (allt ? 2'b01 : 2'b10);
    endfunction

    function automatic logic [NV-1:0] m_dc(input logic [2*NV-1:0] a);
        logic [NV-1:0] r;
        for (int i = 0; i < NV; i++) begin
            r[i] = 1'b1;
            for (int c = 0; c < NC; c++) begin
                if (PM[c*NV+i]) begin
                    logic other;
                    other = 0;
                    for (int v = 0; v < NV; v++)
                        if (v != i && m_lit_true(a, c, v)) other = 1;
                    if (!other) r[i] = 1'b0;
                end
            end
        end
        return r;
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h (in=%b)", tag, what, act, exp, assign_i);
        end
    endtask

    task automatic apply(input logic [2*NV-1:0] a);
        @(negedge clk);
        assign_i = a;
        @(posedge clk);
        #1;
    endtask

    task automatic check_all(input string tf, input string td);
        check(tf, "formula", 32'(formula_o), 32'(m_formula(assign_i)));
        check(td, "dont_care", 32'(dont_care_o), 32'(m_dc(assign_i)));
    endtask

    initial begin
        #(200_000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [2*NV-1:0] a;
        logic [2*NV-1:0] b;
        logic [NV-1:0]   ref_dc;
        int unsigned     seed;
        seed = $urandom(32'd20240611);
        assign_i = {NV{2'b10}};
        repeat (3) @(posedge clk);
        #1;
        // Reset state: all unassigned -> open formula, only var5 flagged (R7, R10)
        check("R7", "reset formula", 32'(formula_o), 32'(2'b10));
        check("R10", "reset dont_care", 32'(dont_care_o), 32'(6'b100000));
        rst_n = 1'b1;

        // Spare code behaves like unassigned (R1)
        apply({NV{2'b11}});
        check("R1", "all-11 formula", 32'(formula_o), 32'(2'b10));
        check("R1", "all-11 dont_care", 32'(dont_care_o), 32'(6'b100000));

        // Full satisfying assignment x0=1, rest 0 (R2, R6)
        apply({2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b01});
        check("R6", "satisfied formula", 32'(formula_o), 32'(2'b01));
        check_all("R2", "R8");

        // x0=0,x1=0 falsifies first clause, rest open (R3, R5)
        apply({2'b10, 2'b10, 2'b10, 2'b10, 2'b00, 2'b00});
        check("R5", "false dominates", 32'(formula_o), 32'(2'b00));
        check_all("R3", "R8");

        // Negated literal of unassigned var stays open: x0=1,x1 open (R4)
        apply({2'b00, 2'b00, 2'b00, 2'b00, 2'b10, 2'b01});
        check("R4", "open negation", 32'(formula_o), 32'(2'b10));

        // Same with spare code for x1 (R1, R4)
        apply({2'b00, 2'b00, 2'b00, 2'b00, 2'b11, 2'b01});
        check("R1", "spare as open", 32'(formula_o), 32'(2'b10));

        // Random partial assignments against the model (R2..R8)
        for (int n = 0; n < 1500; n++) begin
            a = 12'($urandom);
            apply(a);
            check_all("R7", "R8");
        end

        // Own value of variable i does not affect its flag (R9)
        for (int n = 0; n < 200; n++) begin
            a = 12'($urandom);
            for (int i = 0; i < NV; i++) begin
                apply(a);
                ref_dc = dont_care_o;
                for (int k = 0; k < 4; k++) begin
                    b = a;
                    b[2*i +: 2] = 2'(k);
                    apply(b);
                    check("R9", "own value independence", 32'(dont_care_o[i]), 32'(ref_dc[i]));
                    check("R10", "unused var flag", 32'(dont_care_o[5]), 32'(1));
                end
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule